// File: doc/BRIEF.md
# Symmetric FIR Filter with Sequenced Coefficient Loader

This block filters two independent signed sample streams, one per sound IF channel. Each channel has its own linear-phase FIR filter, used to shape data or to limit bandwidth. Every filter has twelve taps and a symmetric response, so it is described by six signed coefficients. Before the multiply, the two samples that sit the same distance from the centre of the delay line are added together. The accumulator is wide enough that it cannot overflow. The result is rounded and then clipped to the sample width.

Coefficients arrive as 16-bit words on a valid/ready configuration port. Only the low byte of each word carries data. A word's address selects the filter block it belongs to. The loader checks that every word arrives in its expected position and collects the values in a shadow bank. Only a complete, correct block is copied to the active bank, and the copy takes one clock cycle. A block that is incomplete or malformed never reaches the filter, and the filter keeps running on the set it already has.

Top module: `lp_fir_filter`

## Requirements
- R1: After reset, both `res_valid` bits are 0, both `res_out` lanes are 0, `cfg_err` is 0 and `cfg_ready` is 1. All active coefficients are zero.
- R2: A block at address 0x01 loads channel 0 with six words. The first word is coefficient 5 and the last is coefficient 0, in descending order. Coefficient k weights the sample pair at delay-line positions 5-k and 6+k, where position 0 holds the newest sample.
- R3: Bits 15:8 of every configuration word are ignored. Both the coefficient value and the preamble comparison use bits 7:0 only, read as signed two's complement.
- R4: A block at address 0x05 loads channel 1 with nine words. The first three are the preamble bytes 0x04, 0x40 and 0x00, in that order. Coefficients 5 down to 0 follow.
- R5: Once part of a block has arrived, the active coefficients do not change until that block completes.
- R6: A preamble word with the wrong value aborts the block. It sets `cfg_err`, which stays at 1 until reset. The active set of both channels is kept.
- R7: During a block, a word whose address differs from the block's own address aborts the block and sets `cfg_err`. That word is discarded. The next word starts a new block from its first position.
- R8: While no block is in progress, a word to any address other than 0x01 or 0x05 is accepted and dropped. It has no effect and does not set `cfg_err`.
- R9: After the last word of a block is accepted, the active set is updated in the cycle that follows. `cfg_ready` is 0 for exactly that one cycle. A sample presented during that cycle is filtered with the new set.
- R10: Each output equals sum(c[k]*(x[5-k]+x[6+k])) divided by 2^7 and rounded half up, where x[0] is the newest sample.
- R11: A result above 32767 gives 32767, and a result below -32768 gives -32768.
- R12: A sample accepted at one clock edge appears on `res_out` after the next edge. `res_valid` is high for that one cycle, and `res_out` holds its value between outputs.
- R13: Loading one channel's block does not change the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Configuration word can be taken |
| cfg_addr | input | 8 | Filter block address |
| cfg_data | input | 16 | Configuration word; low byte carries the value |
| cfg_err | output | 1 | Sticky flag for an aborted block |
| smp_valid | input | 2 | Per-channel input sample strobe |
| smp_in | input | 2x16 | Per-channel signed input sample |
| res_valid | output | 2 | Per-channel output strobe |
| res_out | output | 2x16 | Per-channel signed filtered sample |

## Verification
A single impulse travels through the whole delay line. It shows each coefficient at the pair position it should drive, which separates a correct load order from a reversed one and a correct pair mapping from a shifted one. Sequences with mixed signs and mixed magnitudes exercise the pre-add of both halves of each pair together. Full-scale runs in both directions force the output to clip, and half-LSB inputs of both signs tell round-half-up apart from truncation. Load sequences that are cut short, that carry a wrong preamble byte, that switch address partway through, or that are sent to an unused address are each followed by samples. These show that the previous coefficient set survived.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

   // count of fixed compatibility bytes ahead of the second channel's coefficients
   localparam int PRE_LEN = 3;

   typedef enum logic {
      LD_IDLE,
      LD_RUN
   } ld_state_e;

   function automatic logic [7:0] preamble_byte(input int idx);
      case (idx)
         0:       return 8'h04;
         1:       return 8'h40;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/lpf_coef_loader.sv
module lpf_coef_loader
   import lpf_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 16,
   parameter int CW = 8,
   parameter int NC = 6,
   parameter logic [AW-1:0] ADDR_A = 'h01,
   parameter logic [AW-1:0] ADDR_B = 'h05
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_valid,
   output logic                         wr_ready,
   input  logic [AW-1:0]                wr_addr,
   input  logic [DW-1:0]                wr_data,
   output logic [1:0][NC-1:0][CW-1:0]   act_coef,
   output logic                         seq_err
);

   localparam int SEQ_MAX = PRE_LEN + NC;
   localparam int PW      = $clog2(SEQ_MAX + 1);

   ld_state_e                st;
   logic                     cur_ch;
   logic [PW-1:0]            pos;
   logic                     commit_pend;
   logic                     commit_ch;
   logic [NC-1:0][CW-1:0]    shadow [2];

   logic take, hit, hit_ch, ch_e, in_pre, last, abort, cwr, start_ok;
   int   pos_i, plen, cidx;

   // upper half of each word carries nothing
   logic unused_hi;
   assign unused_hi = ^wr_data[DW-1:8];

   assign wr_ready = !commit_pend;

   always_comb begin
      take     = wr_valid && wr_ready;
      hit      = (wr_addr == ADDR_A) || (wr_addr == ADDR_B);
      hit_ch   = (wr_addr == ADDR_B);
      ch_e     = (st == LD_RUN) ? cur_ch : hit_ch;
      pos_i    = (st == LD_RUN) ? int'(pos) : 0;
      plen     = ch_e ? PRE_LEN : 0;
      in_pre   = pos_i < plen;
      cidx     = NC - 1 - (pos_i - plen);
      last     = !in_pre && (cidx == 0);
      start_ok = (st == LD_RUN) || hit;
      abort    = 1'b0;
      cwr      = 1'b0;
      if (take) begin
         if ((st == LD_RUN) && (!hit || (hit_ch != cur_ch))) begin
            abort = 1'b1;
         end else if (start_ok) begin
            if (in_pre) abort = (wr_data[7:0] != preamble_byte(pos_i));
            else        cwr   = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= LD_IDLE;
         cur_ch      <= 1'b0;
         pos         <= '0;
         commit_pend <= 1'b0;
         commit_ch   <= 1'b0;
         seq_err     <= 1'b0;
      end else begin
         commit_pend <= 1'b0;
         if (abort) begin
            st      <= LD_IDLE;
            pos     <= '0;
            seq_err <= 1'b1;
         end else if (take && start_ok) begin
            cur_ch <= ch_e;
            if (cwr && last) begin
               st          <= LD_IDLE;
               pos         <= '0;
               commit_pend <= 1'b1;
               commit_ch   <= ch_e;
            end else begin
               st  <= LD_RUN;
               pos <= PW'(pos_i + 1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '{default: '0};
      end else if (cwr) begin
         for (int k = 0; k < NC; k++) begin
            if (k == cidx) shadow[ch_e][k] <= wr_data[CW-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_coef <= '0;
      end else if (commit_pend) begin
         act_coef[commit_ch] <= shadow[commit_ch];
      end
   end

endmodule

// File: rtl/lpf_sym_core.sv
module lpf_sym_core #(
   parameter int SW   = 16,
   parameter int CW   = 8,
   parameter int NC   = 6,
   parameter int FRAC = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_vld,
   input  logic [SW-1:0]         in_smp,
   input  logic [NC-1:0][CW-1:0] coef,
   output logic                  out_vld,
   output logic [SW-1:0]         out_smp
);

   localparam int NT  = 2 * NC;
   localparam int PAW = SW + 1;
   localparam int PRW = PAW + CW;
   localparam int ACW = PRW + $clog2(NC + 1);
   localparam logic signed [ACW-1:0] SMAX = {{(ACW-SW+1){1'b0}}, {(SW-1){1'b1}}};
   localparam logic signed [ACW-1:0] SMIN = {{(ACW-SW+1){1'b1}}, {(SW-1){1'b0}}};

   logic signed [SW-1:0]  line [NT];
   logic signed [PRW-1:0] prod [NC];
   logic signed [ACW-1:0] acc;
   logic signed [ACW-1:0] scaled;
   logic        [SW-1:0]  clip;
   logic                  shift_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line <= '{default: '0};
      end else if (in_vld) begin
         line[0] <= $signed(in_smp);
         for (int i = 1; i < NT; i++) line[i] <= line[i-1];
      end
   end

   // fold the line: taps at equal distance from the centre share one multiplier
   for (genvar k = 0; k < NC; k++) begin : g_pair
      logic signed [PAW-1:0] psum;
      assign psum    = PAW'(line[NC-1-k]) + PAW'(line[NC+k]);
      assign prod[k] = PRW'(psum) * PRW'($signed(coef[k]));
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < NC; k++) acc = acc + ACW'(prod[k]);
   end

   if (FRAC > 0) begin : g_round
      localparam logic signed [ACW-1:0] HALF = ACW'(1) <<< (FRAC - 1);
      logic signed [ACW-1:0] biased;
      assign biased = acc + HALF;
      assign scaled = biased >>> FRAC;
   end else begin : g_noround
      assign scaled = acc;
   end

   always_comb begin
      if (scaled > SMAX)      clip = SMAX[SW-1:0];
      else if (scaled < SMIN) clip = SMIN[SW-1:0];
      else                    clip = scaled[SW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_d <= 1'b0;
         out_vld <= 1'b0;
         out_smp <= '0;
      end else begin
         shift_d <= in_vld;
         out_vld <= shift_d;
         if (shift_d) out_smp <= clip;
      end
   end

endmodule

// File: rtl/lp_fir_filter.sv
module lp_fir_filter #(
   parameter int SMP_W     = 16,
   parameter int COEF_W    = 8,
   parameter int HALF_TAPS = 6,
   parameter int FRAC_W    = 7,
   parameter int ADDR_W    = 8,
   parameter int WORD_W    = 16,
   parameter logic [ADDR_W-1:0] ADDR_A = 'h01,
   parameter logic [ADDR_W-1:0] ADDR_B = 'h05
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_valid,
   output logic                   cfg_ready,
   input  logic [ADDR_W-1:0]      cfg_addr,
   input  logic [WORD_W-1:0]      cfg_data,
   output logic                   cfg_err,
   input  logic [1:0]             smp_valid,
   input  logic [1:0][SMP_W-1:0]  smp_in,
   output logic [1:0]             res_valid,
   output logic [1:0][SMP_W-1:0]  res_out
);

   localparam int NCH = 2;

   if (SMP_W < 2 || SMP_W > 30) begin : g_bad_smp
      $error("lp_fir_filter: SMP_W out of range");
   end
   if (COEF_W < 2 || COEF_W > 8) begin : g_bad_coef
      $error("lp_fir_filter: COEF_W must lie in 2..8");
   end
   if (HALF_TAPS < 1) begin : g_bad_taps
      $error("lp_fir_filter: HALF_TAPS must be positive");
   end
   if (FRAC_W < 0 || FRAC_W > SMP_W + COEF_W) begin : g_bad_frac
      $error("lp_fir_filter: FRAC_W out of range");
   end
   if (WORD_W < 9) begin : g_bad_word
      $error("lp_fir_filter: WORD_W must exceed one byte");
   end
   if (ADDR_A == ADDR_B) begin : g_bad_addr
      $error("lp_fir_filter: block addresses must differ");
   end

   logic [1:0][HALF_TAPS-1:0][COEF_W-1:0] act_coef;

   lpf_coef_loader #(
      .AW     (ADDR_W),
      .DW     (WORD_W),
      .CW     (COEF_W),
      .NC     (HALF_TAPS),
      .ADDR_A (ADDR_A),
      .ADDR_B (ADDR_B)
   ) u_loader (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (cfg_valid),
      .wr_ready (cfg_ready),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_data),
      .act_coef (act_coef),
      .seq_err  (cfg_err)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      lpf_sym_core #(
         .SW   (SMP_W),
         .CW   (COEF_W),
         .NC   (HALF_TAPS),
         .FRAC (FRAC_W)
      ) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .in_vld  (smp_valid[c]),
         .in_smp  (smp_in[c]),
         .coef    (act_coef[c]),
         .out_vld (res_valid[c]),
         .out_smp (res_out[c])
      );
   end

endmodule

// File: rtl/lp_fir_filter_chk.sv
module lp_fir_filter_chk #(
   parameter int SW = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_valid,
   input logic                cfg_ready,
   input logic                cfg_err,
   input logic [1:0]          smp_valid,
   input logic [1:0]          res_valid,
   input logic [1:0][SW-1:0]  res_out
);

   // R9: the commit stall lasts one cycle only
   p_ready_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ready |=> cfg_ready);

   // R9: a stall only follows an offered word
   p_ready_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ready |-> $past(cfg_valid));

   // R6: error flag is sticky until reset
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

   // R7: error only arises from a word that was accepted
   p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_err) |-> $past(cfg_valid && cfg_ready));

   for (genvar c = 0; c < 2; c++) begin : g_lane
      // R12: an output strobe follows an input strobe by two edges
      p_res_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid[c] |-> $past(smp_valid[c], 2));

      // R12: output holds between strobes
      p_res_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
         !res_valid[c] |-> $stable(res_out[c]));
   end

endmodule

bind lp_fir_filter lp_fir_filter_chk #(.SW(SMP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_valid (cfg_valid),
   .cfg_ready (cfg_ready),
   .cfg_err   (cfg_err),
   .smp_valid (smp_valid),
   .res_valid (res_valid),
   .res_out   (res_out)
);

// File: tb/lp_fir_filter_bench.sv
module lp_fir_filter_bench;

   localparam int NC   = 6;
   localparam int FR   = 7;
   localparam int SMAX = 32767;
   localparam int SMIN = -32768;
   localparam int NVEC = 20;
   localparam int VEC [NVEC] = '{1000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                                 -2000, 3000, -4000, 5000, 7, -7, 12345, -12345};
   localparam int SET_A [NC]   = '{127, 64, 32, -16, 5, -3};
   localparam int SET_B [NC]   = '{-50, 20, 10, 100, -1, 8};
   localparam int SET_C [NC]   = '{1, 2, 3, 4, 5, 6};
   localparam int SET_MAX [NC] = '{127, 127, 127, 127, 127, 127};
   localparam int SET_RND [NC] = '{0, 0, 0, 0, 0, 1};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_valid = 1'b0;
   logic             cfg_ready;
   logic [7:0]       cfg_addr = '0;
   logic [15:0]      cfg_data = '0;
   logic             cfg_err;
   logic [1:0]       smp_valid = '0;
   logic [1:0][15:0] smp_in = '0;
   logic [1:0]       res_valid;
   logic [1:0][15:0] res_out;

   int n_run  = 0;
   int n_fail = 0;
   int m_coef [2][NC];
   int m_line [2][2*NC];

   always #4ns clk = ~clk;

   lp_fir_filter u_lp_fir_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_valid (cfg_valid),
      .cfg_ready (cfg_ready),
      .cfg_addr  (cfg_addr),
      .cfg_data  (cfg_data),
      .cfg_err   (cfg_err),
      .smp_valid (smp_valid),
      .smp_in    (smp_in),
      .res_valid (res_valid),
      .res_out   (res_out)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int model_out(input int ch);
      longint acc = 0;
      longint r;
      for (int k = 0; k < NC; k++)
         acc += longint'(m_coef[ch][k]) * longint'(m_line[ch][NC-1-k] + m_line[ch][NC+k]);
      r = (acc + 64) >>> FR;
      if (r > SMAX) r = SMAX;
      if (r < SMIN) r = SMIN;
      return int'(r);
   endfunction

   function automatic int rd(input int ch);
      return int'($signed(res_out[ch]));
   endfunction

   task automatic clear_model();
      for (int c = 0; c < 2; c++) begin
         for (int k = 0; k < NC; k++) m_coef[c][k] = 0;
         for (int i = 0; i < 2*NC; i++) m_line[c][i] = 0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      clear_model();
   endtask

   task automatic put_word(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      while (!cfg_ready) @(negedge clk);
      cfg_valid = 1'b1;
      cfg_addr  = a;
      cfg_data  = d;
      @(negedge clk);
      cfg_valid = 1'b0;
      cfg_data  = '0;
   endtask

   // upper byte filled with junk on purpose (R3)
   task automatic load_set(input int ch, input int cv [NC]);
      logic [7:0] a;
      a = (ch == 1) ? 8'h05 : 8'h01;
      if (ch == 1) begin
         put_word(a, 16'hC304);
         put_word(a, 16'h5A40);
         put_word(a, 16'hFF00);
      end
      for (int k = NC - 1; k >= 0; k--) put_word(a, {8'hA5 ^ 8'(k), cv[k][7:0]});
      for (int k = 0; k < NC; k++) m_coef[ch][k] = cv[k];
   endtask

   task automatic push_sample(input int ch, input int v);
      @(negedge clk);
      smp_valid[ch] = 1'b1;
      smp_in[ch]    = 16'(v);
      @(negedge clk);
      smp_valid[ch] = 1'b0;
      for (int i = 2*NC - 1; i > 0; i--) m_line[ch][i] = m_line[ch][i-1];
      m_line[ch][0] = v;
      @(negedge clk);
   endtask

   task automatic push_check(input int ch, input int v, input string req);
      push_sample(ch, v);
      check(req, "filtered output", rd(ch), model_out(ch));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      clear_model();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1", "res_valid", int'(res_valid), 0);
      check("R1", "res_out ch0", rd(0), 0);
      check("R1", "res_out ch1", rd(1), 0);
      check("R1", "cfg_err", int'(cfg_err), 0);
      check("R1", "cfg_ready", int'(cfg_ready), 1);
      push_check(0, 1234, "R1");

      // R2, R3, R9: load channel 0 and watch the one-cycle commit stall
      load_set(0, SET_A);
      check("R9", "ready in commit cycle", int'(cfg_ready), 0);
      @(negedge clk);
      check("R9", "ready after commit", int'(cfg_ready), 1);

      // R2, R10, R12: walk the stimulus table on channel 0
      for (int i = 0; i < NVEC; i++) begin
         push_sample(0, VEC[i]);
         check("R12", "res_valid strobe", int'(res_valid[0]), 1);
         check("R10", "table output", rd(0), model_out(0));
      end
      begin
         int held;
         held = rd(0);
         repeat (3) @(negedge clk);
         check("R12", "res_valid low when idle", int'(res_valid[0]), 0);
         check("R12", "res_out held", rd(0), held);
      end

      // R13: channel 1 still has zero coefficients
      push_check(1, 5000, "R13");
      check("R13", "ch1 zero output", rd(1), 0);

      // R4: channel 1 with preamble
      load_set(1, SET_B);
      check("R4", "cfg_err after good block", int'(cfg_err), 0);
      for (int i = 0; i < 14; i++) push_check(1, (i == 0) ? 900 : ((i % 3) - 1) * 333, "R4");
      push_check(0, 777, "R13");

      // R8: idle word to an unused address
      put_word(8'h33, 16'h0012);
      check("R8", "cfg_err", int'(cfg_err), 0);
      check("R8", "cfg_ready", int'(cfg_ready), 1);
      push_check(0, -555, "R8");
      // a following block still loads from its first word
      load_set(0, SET_A);
      push_check(0, 4321, "R8");

      // R5: partial block leaves the active set alone
      put_word(8'h01, 16'h0006);
      put_word(8'h01, 16'h0005);
      put_word(8'h01, 16'h0004);
      push_check(0, 2500, "R5");
      push_check(0, -1300, "R5");
      check("R5", "cfg_err", int'(cfg_err), 0);

      // R7: address change mid-block aborts
      put_word(8'h05, 16'h0004);
      check("R7", "cfg_err", int'(cfg_err), 1);
      push_check(0, 600, "R7");
      push_check(1, 600, "R7");
      load_set(0, SET_C);
      for (int i = 0; i < 6; i++) push_check(0, 100 * (i + 1), "R7");
      check("R6", "cfg_err sticky", int'(cfg_err), 1);

      // R1: second reset clears the flag and the coefficients
      do_reset();
      check("R1", "cfg_err after reset", int'(cfg_err), 0);
      push_check(0, 3000, "R1");
      check("R1", "zero output after reset", rd(0), 0);

      // R6: wrong preamble byte
      load_set(1, SET_B);
      put_word(8'h05, 16'h0004);
      put_word(8'h05, 16'h0041);
      check("R6", "cfg_err on bad preamble", int'(cfg_err), 1);
      push_check(1, 1111, "R6");
      push_check(1, -2222, "R6");
      put_word(8'h05, 16'h0004);
      put_word(8'h05, 16'h0040);
      put_word(8'h05, 16'h0001);
      push_check(1, 3333, "R6");
      load_set(1, SET_A);
      push_check(1, 1500, "R6");
      check("R6", "cfg_err still set", int'(cfg_err), 1);

      // R9: sample offered in the commit cycle sees the new set
      load_set(0, SET_RND);
      smp_valid[0] = 1'b1;
      smp_in[0]    = 16'(64);
      @(negedge clk);
      smp_valid[0] = 1'b0;
      for (int i = 2*NC - 1; i > 0; i--) m_line[0][i] = m_line[0][i-1];
      m_line[0][0] = 64;
      @(negedge clk);
      check("R9", "new set used at once", rd(0), 1);

      // R10: half-LSB rounding in both directions
      for (int i = 0; i < 12; i++) push_sample(0, 0);
      push_sample(0, 64);
      check("R10", "+0.5 rounds up", rd(0), 1);
      for (int i = 0; i < 12; i++) push_sample(0, 0);
      push_sample(0, -64);
      check("R10", "-0.5 rounds up", rd(0), 0);
      push_sample(0, -192);
      check("R10", "-1.5 rounds up", rd(0), -1);

      // R11: saturation at both rails
      load_set(0, SET_MAX);
      for (int i = 0; i < 12; i++) push_sample(0, SMAX);
      check("R11", "positive clip", rd(0), SMAX);
      for (int i = 0; i < 12; i++) push_sample(0, SMIN);
      check("R11", "negative clip", rd(0), SMIN);
      check("R11", "model agrees", rd(0), model_out(0));

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule